// File: doc/BRIEF.md
# Integrator Step Charge Extractor

This block sits behind an ADC that samples a slowly decaying analog charge integrator. Each particle pulse shows up as a sudden step in the integrator level, while the decay between samples is slow: the time constant spans about 128 sample periods. The block recovers the charge of a pulse as the difference between the newest valid sample and the one before it. It then drops steps too small to be real hits, so that downstream logic sees a zero word instead of baseline noise.

Samples enter on a 14-bit bus with a valid strobe, nominally at 35 MHz. The block registers the step one edge after the sample is taken. It then takes the step's magnitude and ORs together every magnitude bit at or above a parameter-selected position. It ANDs the step with that OR result and registers the output one edge later. The result is a signed charge word with a valid strobe and a hit flag. After reset, the first valid sample only loads the history register and produces no output.

Top module: `cde_charge_extract`

## Requirements
- R1: After a synchronous active-high reset, `chg_valid`, `chg_data` and `chg_hit` read zero. The first valid sample accepted after reset produces no output strobe.
- R2: For every later valid sample, the charge word equals the current sample minus the previous valid sample, both taken as unsigned values.
- R3: The charge word is 15-bit two's complement and never wraps. A step from 0 to 16383 reads +16383, and a step from 16383 to 0 reads -16383.
- R4: With the default threshold position of 4, a step is a hit exactly when some bit of its magnitude at position 4 or above is set, which means |step| >= 16.
- R5: A step that is not a hit still produces `chg_valid` = 1, but with `chg_data` = 0 and `chg_hit` = 0. A hit produces `chg_hit` = 1 and the unmodified step.
- R6: The output for a sample taken at clock edge k appears right after edge k+1, and `chg_valid` pulses for that one cycle only.
- R7: While `chg_valid` is 0, `chg_data` and `chg_hit` are both 0.
- R8: Data on the sample bus while `smp_valid` is 0 is ignored. The previous-sample register keeps the last valid sample across idle cycles of any length.
- R9: A reset in the middle of a stream clears the history, so the next valid sample primes the register again and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Unsigned ADC sample |
| chg_valid | output | 1 | Charge word strobe |
| chg_data | output | 15 | Signed charge word, zero when suppressed |
| chg_hit | output | 1 | Step met the threshold |

## Verification
The bench targets the threshold edges in both polarities: ±15 must be suppressed and ±16 must pass. A design that compares against the wrong bit, or takes the magnitude of negative steps incorrectly, lets one of these through or blocks it. Full-scale steps in both directions expose a difference carried in only 14 bits, which would show a wrapped sign. Gaps of idle cycles carrying garbage on the bus, and a reset in the middle of a stream, expose a history register that loads without the strobe or that survives reset. Either fault produces a wrong step or a spurious first output. Back-to-back samples pin down the exact latency: an extra or missing stage shifts every result by one cycle.

// File: rtl/cde_pkg.sv
package cde_pkg;

  localparam int unsigned CDE_SAMPLE_W = 14;
  localparam int unsigned CDE_THR_LSB  = 4;

  typedef enum logic {
    HIST_EMPTY  = 1'b0,
    HIST_PRIMED = 1'b1
  } hist_state_e;

endpackage

// File: rtl/cde_history.sv
module cde_history #(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic [SAMPLE_W-1:0] prev_data,
  output logic                prime_evt,
  output logic                step_evt
);

  cde_pkg::hist_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= cde_pkg::HIST_EMPTY;
      prev_data <= '0;
    end else if (in_vld) begin
      state_q   <= cde_pkg::HIST_PRIMED;
      prev_data <= in_data;
    end
  end

  // first accepted sample only fills the history
  assign prime_evt = in_vld && (state_q == cde_pkg::HIST_EMPTY);
  assign step_evt  = in_vld && (state_q == cde_pkg::HIST_PRIMED);

endmodule

// File: rtl/cde_step.sv
module cde_step #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned DIFF_W   = SAMPLE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_evt,
  input  logic [SAMPLE_W-1:0]      cur_data,
  input  logic [SAMPLE_W-1:0]      prev_data,
  output logic                     step_vld,
  output logic signed [DIFF_W-1:0] step_q
);

  // zero-extend both operands by one bit, then subtract in signed form
  function automatic logic signed [DIFF_W-1:0] step_of(
    input logic [SAMPLE_W-1:0] cur,
    input logic [SAMPLE_W-1:0] prev
  );
    logic signed [DIFF_W-1:0] a;
    logic signed [DIFF_W-1:0] b;
    a = $signed({{(DIFF_W-SAMPLE_W){1'b0}}, cur});
    b = $signed({{(DIFF_W-SAMPLE_W){1'b0}}, prev});
    return a - b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      step_vld <= 1'b0;
      step_q   <= '0;
    end else begin
      step_vld <= step_evt;
      step_q   <= step_evt ? step_of(cur_data, prev_data) : '0;
    end
  end

endmodule

// File: rtl/cde_gate.sv
module cde_gate #(
  parameter int unsigned DIFF_W  = 15,
  parameter int unsigned THR_LSB = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step_vld,
  input  logic signed [DIFF_W-1:0] step_q,
  output logic                     chg_valid,
  output logic signed [DIFF_W-1:0] chg_data,
  output logic                     chg_hit,
  output logic                     hit_now
);

  localparam int unsigned UPPER_N = DIFF_W - THR_LSB;

  function automatic logic [DIFF_W-1:0] magnitude_of(
    input logic signed [DIFF_W-1:0] v
  );
    return v[DIFF_W-1] ? (~v + 1'b1) : v;
  endfunction

  logic [DIFF_W-1:0]  mag;
  logic [UPPER_N-1:0] upper_bits;
  logic [DIFF_W-1:0]  hit_mask;
  logic signed [DIFF_W-1:0] gated;

  assign mag = magnitude_of(step_q);

  // collect every magnitude bit that counts toward the threshold
  for (genvar b = THR_LSB; b < DIFF_W; b++) begin : g_upper
    assign upper_bits[b - THR_LSB] = mag[b];
  end

  assign hit_now  = |upper_bits;
  assign hit_mask = {DIFF_W{hit_now}};
  assign gated    = step_q & hit_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_valid <= 1'b0;
      chg_data  <= '0;
      chg_hit   <= 1'b0;
    end else begin
      chg_valid <= step_vld;
      chg_data  <= step_vld ? gated : '0;
      chg_hit   <= step_vld && hit_now;
    end
  end

endmodule

// File: rtl/cde_charge_extract.sv
module cde_charge_extract #(
  parameter int unsigned SAMPLE_W = cde_pkg::CDE_SAMPLE_W,
  parameter int unsigned THR_LSB  = cde_pkg::CDE_THR_LSB
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_valid,
  input  logic [SAMPLE_W-1:0]          smp_data,
  output logic                         chg_valid,
  output logic signed [SAMPLE_W:0]     chg_data,
  output logic                         chg_hit
);

  localparam int unsigned DIFF_W = SAMPLE_W + 1;

  logic [SAMPLE_W-1:0]      prev_data;
  logic                     prime_evt;
  logic                     step_evt;
  logic                     step_vld;
  logic signed [DIFF_W-1:0] step_q;
  logic                     hit_now;

  cde_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (smp_valid),
    .in_data   (smp_data),
    .prev_data (prev_data),
    .prime_evt (prime_evt),
    .step_evt  (step_evt)
  );

  cde_step #(.SAMPLE_W(SAMPLE_W), .DIFF_W(DIFF_W)) u_step (
    .clk       (clk),
    .rst       (rst),
    .step_evt  (step_evt),
    .cur_data  (smp_data),
    .prev_data (prev_data),
    .step_vld  (step_vld),
    .step_q    (step_q)
  );

  cde_gate #(.DIFF_W(DIFF_W), .THR_LSB(THR_LSB)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .step_vld  (step_vld),
    .step_q    (step_q),
    .chg_valid (chg_valid),
    .chg_data  (chg_data),
    .chg_hit   (chg_hit),
    .hit_now   (hit_now)
  );

endmodule

// File: rtl/cde_checker.sv
module cde_checker #(
  parameter int unsigned DIFF_W  = 15,
  parameter int unsigned THR_LSB = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_valid,
  input logic                     prime_evt,
  input logic                     step_vld,
  input logic                     hit_now,
  input logic                     chg_valid,
  input logic signed [DIFF_W-1:0] chg_data,
  input logic                     chg_hit
);

  logic [DIFF_W-1:0] out_mag;
  logic [DIFF_W-1:0] thr_val;
  logic [DIFF_W-1:0] most_neg;

  assign out_mag  = chg_data[DIFF_W-1] ? (~chg_data + 1'b1) : chg_data;
  assign thr_val  = DIFF_W'(1) << THR_LSB;
  assign most_neg = DIFF_W'(1) << (DIFF_W - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !chg_valid);                                          // R1
  AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (rst)
    prime_evt |=> !step_vld);                                            // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> (chg_data != most_neg));                               // R3
  AST_HIT_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
    (chg_valid && chg_hit) |-> (out_mag >= thr_val));                    // R4
  AST_HIT_FROM_STAGE: assert property (@(posedge clk) disable iff (rst)
    step_vld |=> (chg_hit == $past(hit_now)));                           // R4
  AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (chg_valid && !chg_hit) |-> (chg_data == '0));                       // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    chg_valid |-> $past(smp_valid, 2));                                  // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !chg_valid |-> (chg_data == '0 && !chg_hit));                        // R7

endmodule

bind cde_charge_extract cde_checker #(.DIFF_W(DIFF_W), .THR_LSB(THR_LSB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .prime_evt (prime_evt),
  .step_vld  (step_vld),
  .hit_now   (hit_now),
  .chg_valid (chg_valid),
  .chg_data  (chg_data),
  .chg_hit   (chg_hit)
);

// File: tb/test_cde_charge_extract.sv
module test_cde_charge_extract;

  localparam int SW = 14;
  localparam int DW = 15;
  localparam int NV = 12;

  // {prev[43:30], cur[29:16], expected word[15:1], expected hit[0]}
  localparam logic [43:0] VEC [NV] = '{
    {14'd1000,  14'd1000,  15'h0000, 1'b0},  // R2 R5 flat
    {14'd1000,  14'd1015,  15'h0000, 1'b0},  // R4 +15 suppressed
    {14'd1000,  14'd1016,  15'h0010, 1'b1},  // R4 +16 passes
    {14'd1000,  14'd985,   15'h0000, 1'b0},  // R4 -15 suppressed
    {14'd1000,  14'd984,   15'h7FF0, 1'b1},  // R4 -16 passes
    {14'd0,     14'd16383, 15'h3FFF, 1'b1},  // R3 full scale up
    {14'd16383, 14'd0,     15'h4001, 1'b1},  // R3 full scale down
    {14'd8192,  14'd8492,  15'h012C, 1'b1},  // R2 +300
    {14'd5000,  14'd4000,  15'h7C18, 1'b1},  // R2 -1000
    {14'd200,   14'd199,   15'h0000, 1'b0},  // R5 -1 suppressed
    {14'd16383, 14'd16368, 15'h0000, 1'b0},  // R4 -15 at top
    {14'd0,     14'd31,    15'h001F, 1'b1}   // R4 +31
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_valid = 1'b0;
  logic [SW-1:0]        smp_data = '0;
  logic                 chg_valid;
  logic signed [DW-1:0] chg_data;
  logic                 chg_hit;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cde_charge_extract i_cde_charge_extract (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .chg_valid (chg_valid),
    .chg_data  (chg_data),
    .chg_hit   (chg_hit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input bit v, input int d, input bit h);
    check(req, "chg_valid", int'(chg_valid), int'(v));
    check(req, "chg_data",  int'(chg_data),  d);
    check(req, "chg_hit",   int'(chg_hit),   int'(h));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input bit v, input int d);
    @(negedge clk);
    smp_valid = v;
    smp_data  = SW'(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #1 check_out("R1", 1'b0, 0, 1'b0);  // reset state

    for (int i = 0; i < NV; i++) begin
      logic signed [DW-1:0] ew;
      ew = $signed(VEC[i][15:1]);
      drive(1'b1, int'(VEC[i][43:30]));
      drive(1'b1, int'(VEC[i][29:16]));
      drive(1'b0, 0);
      @(posedge clk);
      #1 check_out("R2/R3/R4/R5 table", 1'b1, int'(ew), VEC[i][0]);
    end

    // R1 R6 R7: prime, then one step, exact timing
    do_reset();
    drive(1'b1, 500);
    drive(1'b1, 600);
    drive(1'b0, 0);
    check_out("R1 first sample silent", 1'b0, 0, 1'b0);
    @(posedge clk);
    #1 check_out("R6 output after two edges", 1'b1, 100, 1'b1);
    @(posedge clk);
    #1 check_out("R7 idle after pulse", 1'b0, 0, 1'b0);

    // R8: garbage on bus while idle must not load history
    drive(1'b0, 12345);
    drive(1'b0, 3);
    drive(1'b0, 9999);
    check_out("R8 idle garbage no output", 1'b0, 0, 1'b0);
    drive(1'b1, 650);
    drive(1'b0, 7777);
    @(posedge clk);
    #1 check_out("R8 step spans gap", 1'b1, 50, 1'b1);

    // R2 R5 R6: back-to-back stream, history now 650
    drive(1'b1, 1000);
    drive(1'b1, 1100);
    drive(1'b1, 1050);
    check_out("R6 stream 1", 1'b1, 350, 1'b1);
    drive(1'b1, 1050);
    check_out("R6 stream 2", 1'b1, 100, 1'b1);
    drive(1'b0, 0);
    check_out("R2 stream 3 negative", 1'b1, -50, 1'b1);
    drive(1'b0, 0);
    check_out("R5 stream 4 suppressed", 1'b1, 0, 1'b0);
    drive(1'b0, 0);
    check_out("R7 stream done", 1'b0, 0, 1'b0);

    // R9: reset mid-stream re-primes
    drive(1'b1, 3000);
    do_reset();
    drive(1'b1, 2000);
    drive(1'b1, 2020);
    drive(1'b0, 0);
    check_out("R9 no output after re-prime", 1'b0, 0, 1'b0);
    @(posedge clk);
    #1 check_out("R9 step after re-prime", 1'b1, 20, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule